// File: doc/BRIEF.md
# Six-Queue Command Slot Arbiter

This block chooses which of six command queues sends the next command word to a set of downstream command buffers. Each queue must be armed before it can send. A software pulse arms a queue, and so can a hardware trigger input. The hardware trigger is set per queue to rising edge, falling edge, high level or low level. The output runs in fixed-length slots. In the last cycle of each slot the block picks the lowest-numbered armed queue whose command is valid and whose destination buffer is not full. It accepts that word through the queue's ready line and presents it at the output on the following clock, together with a one-cycle strobe.

When no queue can send, the slot still produces a word: a null word whose marker bit (the MSB) is set, so that a receiver can discard it. This happens when nothing is armed or valid, and also when every candidate destination is full. A queue disarms once its end-of-queue word has been transferred. Queue 0 is the preemptive queue. Arming it from the disarmed state raises a flush pulse, which tells the converter side to abort the current conversion and skip the words already buffered. Each command word carries a continuation flag. If another queue takes a slot while a multi-word sequence is still open, the block raises a coherency interrupt.

Top module: `cmdq_arbiter`

## Requirements
- R1: `word_strobe` is high for exactly one cycle in every SLOT_LEN cycles (default 4). After reset is released, the first strobe appears on the SLOT_LEN-th rising edge.
- R2: In the last cycle of a slot, `cmd_ready` is one-hot on the lowest-index queue that is armed, has `cmd_valid` set, and whose destination (`cmd_dest`, 2 bits per queue) indexes a clear bit of `dest_full`. In all other cycles `cmd_ready` is zero.
- R3: A transferred command appears on `word_out` with the strobe on the next clock, as {marker=0, dest[1:0], data[15:0]}.
- R4: If no queue is eligible in a slot, the strobe carries the null word: marker bit 18 set and all other bits zero.
- R5: If armed queues hold valid commands but all of their destinations are full, the slot emits the null word and no `cmd_ready` is raised.
- R6: A one-cycle pulse on `sw_trig[i]` arms queue i in every trigger mode.
- R7: `trig_mode` holds 3 bits per queue: 0 = hardware trigger off, 1 = rising edge, 2 = falling edge, 3 = high level, 4 = low level (other values are off). A matching condition on `hw_trig[i]` arms the queue. Edges are measured against the value from the previous clock, and that value is 0 after reset.
- R8: Transferring a word that has `cmd_eoq` set disarms its queue. A trigger event in the same cycle keeps the queue armed.
- R9: A trigger event on queue 0 while queue 0 is disarmed produces a one-cycle `flush_pulse` on the next clock.
- R10: `coher_irq` pulses for one cycle, together with the strobe, when a queue transfers a word while a different queue's last transferred word had `cmd_more` set. That open sequence is then dropped.
- R11: While `rst_n` is low, every queue is disarmed, `cmd_ready`, `word_strobe`, `flush_pulse` and `coher_irq` are 0, and `word_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_trig | input | 6 | Software arm pulse, one bit per queue |
| hw_trig | input | 6 | Hardware trigger line, one bit per queue |
| trig_mode | input | 18 | Trigger mode, 3 bits per queue |
| cmd_valid | input | 6 | Queue holds a command word |
| cmd_data | input | 96 | Command payload, 16 bits per queue |
| cmd_dest | input | 12 | Destination buffer index, 2 bits per queue |
| cmd_eoq | input | 6 | Word is the last of its queue |
| cmd_more | input | 6 | Word continues a multi-word sequence |
| cmd_ready | output | 6 | Word accepted this cycle |
| dest_full | input | 4 | Destination buffer cannot accept a word |
| word_strobe | output | 1 | New word on `word_out` |
| word_out | output | 19 | {marker, dest, data}; marker set means null |
| flush_pulse | output | 1 | Abort conversion and skip buffered words |
| coher_irq | output | 1 | Command coherency lost |

## Verification
The hardest situation to reach is a broken sequence. One queue must have sent a word with the continuation flag, and before that sequence ends, a lower-numbered queue must be armed, have a valid word and find its destination free in the very next slot. The directed part gets there by arming a queue whose words carry the continuation flag, waiting for one of its strobes, and then arming a higher-priority queue through software. A randomized phase then varies trigger modes, full flags, sequence lengths and continuation flags, and a behavioural model checks every output on every clock.

// File: rtl/cmdq_pkg.sv
// Shared definitions for the command slot arbiter.
package cmdq_pkg;

    localparam int TRG_MODE_W = 3;

    // Hardware trigger condition per queue; unlisted codes mean "off".
    typedef enum logic [TRG_MODE_W-1:0] {
        TRG_OFF  = 3'd0,
        TRG_RISE = 3'd1,
        TRG_FALL = 3'd2,
        TRG_HIGH = 3'd3,
        TRG_LOW  = 3'd4
    } trig_mode_e;

endpackage

// File: rtl/cmdq_trigger.sv
// Per-queue arming logic.
// Decodes each queue's hardware trigger mode against the line's previous
// value, ORs in the software pulse and keeps an armed flag per queue.
// Assumes hw_trig is already synchronous to clk. A set beats a disarm in
// the same cycle.
module cmdq_trigger
    import cmdq_pkg::*;
#(
    parameter int NQ = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NQ-1:0]          sw_trig,
    input  logic [NQ-1:0]          hw_trig,
    input  logic [NQ*TRG_MODE_W-1:0] trig_mode,
    input  logic [NQ-1:0]          disarm,
    output logic [NQ-1:0]          armed,
    output logic [NQ-1:0]          trig_evt
);

    logic [NQ-1:0] hw_prev;

    // Remember the previous hardware line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hw_prev <= '0;
        else        hw_prev <= hw_trig;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_q
        trig_mode_e mode;
        logic       hw_hit;

        assign mode = trig_mode_e'(trig_mode[g*TRG_MODE_W +: TRG_MODE_W]);

        // Evaluate this queue's hardware trigger condition.
        always_comb begin
            case (mode)
                TRG_RISE: hw_hit = hw_trig[g] & ~hw_prev[g];
                TRG_FALL: hw_hit = ~hw_trig[g] & hw_prev[g];
                TRG_HIGH: hw_hit = hw_trig[g];
                TRG_LOW:  hw_hit = ~hw_trig[g];
                default:  hw_hit = 1'b0;
            endcase
        end

        assign trig_evt[g] = sw_trig[g] | hw_hit;

        // Armed flag: set by an event, cleared by the end-of-queue transfer.
        always_ff @(posedge clk) begin
            if (!rst_n)           armed[g] <= 1'b0;
            else if (trig_evt[g]) armed[g] <= 1'b1;
            else if (disarm[g])   armed[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/cmdq_pick.sv
// Fixed-priority winner selection.
// A queue is eligible when armed, valid, and its destination buffer is not
// full. The lowest eligible index wins. Purely combinational.
module cmdq_pick #(
    parameter int NQ     = 6,
    parameter int NDEST  = 4,
    parameter int DEST_W = 2
) (
    input  logic [NQ-1:0]        armed,
    input  logic [NQ-1:0]        cmd_valid,
    input  logic [NQ*DEST_W-1:0] cmd_dest,
    input  logic [NDEST-1:0]     dest_full,
    output logic [NQ-1:0]        grant,
    output logic                 any
);

    logic [NQ-1:0] elig;

    for (genvar g = 0; g < NQ; g++) begin : g_elig
        logic [DEST_W-1:0] d;
        assign d       = cmd_dest[g*DEST_W +: DEST_W];
        assign elig[g] = armed[g] & cmd_valid[g] & ~dest_full[d];
    end

    // Scan from the lowest priority upward so the lowest index wins last.
    always_comb begin
        grant = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    assign any = |elig;

endmodule

// File: rtl/cmdq_coherency.sv
// Multi-word sequence tracker.
// Records which queue has an open sequence (last word had the continuation
// flag) and pulses an interrupt when another queue takes a slot first.
// Assumes at most one transfer per cycle (grant one-hot).
module cmdq_coherency #(
    parameter int NQ = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer,
    input  logic [NQ-1:0] grant,
    input  logic          more_win,
    output logic          irq
);

    logic [NQ-1:0] open_seq;

    // Update open sequences and flag interruptions on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_seq <= '0;
            irq      <= 1'b0;
        end else if (xfer) begin
            irq      <= |(open_seq & ~grant);
            open_seq <= grant & {NQ{more_win}};
        end else begin
            irq      <= 1'b0;
        end
    end

endmodule

// File: rtl/cmdq_arbiter.sv
// Six-queue command slot arbiter (top).
// Runs fixed-length output slots. In the last cycle of each slot it accepts
// one word from the winning queue and registers it, or a null word, onto
// word_out with a strobe. It also produces the queue-0 flush pulse and the
// coherency interrupt. Assumes SLOT_LEN >= 2 and upstream queues that hold
// data stable while valid.
module cmdq_arbiter
    import cmdq_pkg::*;
#(
    parameter int NQ       = 6,
    parameter int CMD_W    = 16,
    parameter int NDEST    = 4,
    parameter int SLOT_LEN = 4,
    localparam int DEST_W  = (NDEST > 1) ? $clog2(NDEST) : 1,
    localparam int WORD_W  = 1 + DEST_W + CMD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NQ-1:0]             sw_trig,
    input  logic [NQ-1:0]             hw_trig,
    input  logic [NQ*TRG_MODE_W-1:0]  trig_mode,
    input  logic [NQ-1:0]             cmd_valid,
    input  logic [NQ*CMD_W-1:0]       cmd_data,
    input  logic [NQ*DEST_W-1:0]      cmd_dest,
    input  logic [NQ-1:0]             cmd_eoq,
    input  logic [NQ-1:0]             cmd_more,
    output logic [NQ-1:0]             cmd_ready,
    input  logic [NDEST-1:0]          dest_full,
    output logic                      word_strobe,
    output logic [WORD_W-1:0]         word_out,
    output logic                      flush_pulse,
    output logic                      coher_irq
);

    localparam int CNT_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_LEN - 1);
    localparam logic [WORD_W-1:0] NULL_WORD = {1'b1, {(WORD_W-1){1'b0}}};

    logic [CNT_W-1:0]  slot_cnt;
    logic              slot_tick;
    logic [NQ-1:0]     armed;
    logic [NQ-1:0]     trig_evt;
    logic [NQ-1:0]     grant;
    logic              any_elig;
    logic              xfer;
    logic [NQ-1:0]     disarm;
    logic [CMD_W-1:0]  win_data;
    logic [DEST_W-1:0] win_dest;
    logic              win_more;

    // Slot timer: the tick marks the last cycle of each output slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                slot_cnt <= '0;
        else if (slot_cnt == LAST) slot_cnt <= '0;
        else                       slot_cnt <= slot_cnt + 1'b1;
    end

    assign slot_tick = (slot_cnt == LAST);

    cmdq_trigger #(.NQ(NQ)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_trig  (sw_trig),
        .hw_trig  (hw_trig),
        .trig_mode(trig_mode),
        .disarm   (disarm),
        .armed    (armed),
        .trig_evt (trig_evt)
    );

    cmdq_pick #(.NQ(NQ), .NDEST(NDEST), .DEST_W(DEST_W)) u_pick (
        .armed    (armed),
        .cmd_valid(cmd_valid),
        .cmd_dest (cmd_dest),
        .dest_full(dest_full),
        .grant    (grant),
        .any      (any_elig)
    );

    assign cmd_ready = grant & {NQ{slot_tick}};
    assign xfer      = slot_tick & any_elig;
    assign disarm    = cmd_ready & cmd_eoq;

    // Multiplex the winning queue's fields (grant is one-hot or zero).
    always_comb begin
        win_data = '0;
        win_dest = '0;
        win_more = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            if (grant[i]) begin
                win_data = cmd_data[i*CMD_W +: CMD_W];
                win_dest = cmd_dest[i*DEST_W +: DEST_W];
                win_more = cmd_more[i];
            end
        end
    end

    cmdq_coherency #(.NQ(NQ)) u_coh (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer    (xfer),
        .grant   (grant),
        .more_win(win_more),
        .irq     (coher_irq)
    );

    // Output word register: loaded once per slot with a command or null.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_strobe <= 1'b0;
            word_out    <= '0;
        end else begin
            word_strobe <= slot_tick;
            if (slot_tick)
                word_out <= xfer ? {1'b0, win_dest, win_data} : NULL_WORD;
        end
    end

    // Flush request when queue 0 is armed from the disarmed state.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_pulse <= 1'b0;
        else        flush_pulse <= trig_evt[0] & ~armed[0];
    end

endmodule

// File: rtl/cmdq_arbiter_chk.sv
// Property checker for cmdq_arbiter, attached by bind.
module cmdq_arbiter_chk #(
    parameter int NQ     = 6,
    parameter int NDEST  = 4,
    parameter int DEST_W = 2,
    parameter int WORD_W = 19
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NQ-1:0]        cmd_valid,
    input logic [NQ*DEST_W-1:0] cmd_dest,
    input logic [NQ-1:0]        cmd_ready,
    input logic [NDEST-1:0]     dest_full,
    input logic                 word_strobe,
    input logic [WORD_W-1:0]    word_out,
    input logic                 flush_pulse,
    input logic                 coher_irq
);

    assert_ready_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_ready));

    for (genvar g = 0; g < NQ; g++) begin : g_rdy
        assert_ready_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_ready[g] |-> (cmd_valid[g] && !dest_full[cmd_dest[g*DEST_W +: DEST_W]]));
    end

    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_strobe |=> !word_strobe);

    assert_null_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && word_out[WORD_W-1]) |-> (word_out[WORD_W-2:0] == '0));

    assert_irq_after_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        coher_irq |-> ($past(|cmd_ready) && word_strobe));

    assert_flush_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |=> !flush_pulse);

endmodule

bind cmdq_arbiter cmdq_arbiter_chk #(
    .NQ(NQ), .NDEST(NDEST), .DEST_W(DEST_W), .WORD_W(WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_dest   (cmd_dest),
    .cmd_ready  (cmd_ready),
    .dest_full  (dest_full),
    .word_strobe(word_strobe),
    .word_out   (word_out),
    .flush_pulse(flush_pulse),
    .coher_irq  (coher_irq)
);

// File: tb/cmdq_arbiter_test.sv
module cmdq_arbiter_test;

    localparam int NQ = 6, CMD_W = 16, NDEST = 4, DW = 2, SLOT = 4;
    localparam int WW = 1 + DW + CMD_W;
    localparam logic [WW-1:0] NULLW = 19'h40000;

    logic clk = 0, rst_n = 0;
    logic [NQ-1:0] sw_trig = 0, hw_trig = 0, cmd_valid = 0, cmd_eoq, cmd_more, cmd_ready;
    logic [NQ*3-1:0] trig_mode = 0;
    logic [NQ*CMD_W-1:0] cmd_data;
    logic [NQ*DW-1:0] cmd_dest;
    logic [NDEST-1:0] dest_full = 0;
    logic word_strobe, flush_pulse, coher_irq;
    logic [WW-1:0] word_out;

    int qcnt[NQ], qlen[NQ], qdest[NQ];
    logic [NQ-1:0] more_en = 0;
    int n_checks = 0, n_fail = 0;

    always #5 clk = ~clk;

    cmdq_arbiter uut (.*);

    // Command sources driven from per-queue counters.
    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            cmd_data[i*CMD_W +: CMD_W] = 16'((i << 12) | (qcnt[i] & 12'hfff));
            cmd_dest[i*DW +: DW]       = DW'(qdest[i]);
            cmd_eoq[i]  = (qcnt[i] % qlen[i]) == qlen[i] - 1;
            cmd_more[i] = more_en[i] && !((qcnt[i] % qlen[i]) == qlen[i] - 1);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    bit m_armed[NQ], m_open[NQ];
    bit m_prev[NQ];
    int m_cnt;
    bit e_strobe, e_flush, e_irq, m_valid_chk;
    logic [WW-1:0] e_word;
    int pend_win = -1;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_armed[i]) begin m_armed[i] = 0; m_open[i] = 0; m_prev[i] = 0; end
            m_cnt = 0; e_strobe = 0; e_flush = 0; e_irq = 0; e_word = '0;
            pend_win = -1; m_valid_chk = 1;
            chk("R11 ready in reset", 32'(cmd_ready), 0);
        end else begin
            bit ev[NQ];
            int win;
            bit tick;
            logic [NQ-1:0] exp_rdy;
            win = -1;
            for (int i = 0; i < NQ; i++) begin
                int md;
                md = int'(trig_mode[i*3 +: 3]);
                ev[i] = sw_trig[i] ||
                        (md == 1 && hw_trig[i] && !m_prev[i]) ||
                        (md == 2 && !hw_trig[i] && m_prev[i]) ||
                        (md == 3 && hw_trig[i]) || (md == 4 && !hw_trig[i]);
            end
            for (int i = NQ - 1; i >= 0; i--)
                if (m_armed[i] && cmd_valid[i] && !dest_full[qdest[i]]) win = i;
            tick = (m_cnt == SLOT - 1);
            exp_rdy = '0;
            if (tick && win >= 0) exp_rdy[win] = 1'b1;
            chk("R2 ready", 32'(cmd_ready), 32'(exp_rdy));
            e_strobe = tick;
            e_flush  = ev[0] && !m_armed[0];
            e_irq    = 0;
            if (tick) begin
                if (win >= 0) begin
                    e_word = {1'b0, DW'(qdest[win]), cmd_data[win*CMD_W +: CMD_W]};
                    for (int k = 0; k < NQ; k++) if (k != win && m_open[k]) e_irq = 1;
                    for (int k = 0; k < NQ; k++) m_open[k] = 0;
                    m_open[win] = cmd_more[win];
                end else e_word = NULLW;
            end
            for (int i = 0; i < NQ; i++) begin
                if (ev[i]) m_armed[i] = 1;
                else if (tick && win == i && cmd_eoq[i]) m_armed[i] = 0;
                m_prev[i] = hw_trig[i];
            end
            pend_win = tick ? win : -1;
            m_cnt = (m_cnt + 1) % SLOT;
        end
    end

    // Compare registered outputs away from the edge; advance sources.
    always @(negedge clk) begin
        if (m_valid_chk) begin
            chk("R1 strobe", 32'(word_strobe), 32'(e_strobe));
            if (e_word[WW-1]) chk("R4 word", 32'(word_out), 32'(e_word));
            else              chk("R3 word", 32'(word_out), 32'(e_word));
            chk("R9 flush", 32'(flush_pulse), 32'(e_flush));
            chk("R10 irq", 32'(coher_irq), 32'(e_irq));
        end
        if (pend_win >= 0) begin qcnt[pend_win]++; pend_win = -1; end
    end

    task automatic wait_strobe();
        do @(negedge clk); while (!word_strobe);
    endtask

    task automatic sw_pulse(input int q);
        @(negedge clk) sw_trig[q] = 1;
        @(negedge clk) sw_trig[q] = 0;
    endtask

    function automatic logic [WW-1:0] wexp(input int q, input int n);
        return {1'b0, DW'(qdest[q]), 16'((q << 12) | n)};
    endfunction

    initial begin
        for (int i = 0; i < NQ; i++) begin qcnt[i] = 0; qlen[i] = 2; qdest[i] = i % NDEST; end
        cmd_valid = '1;
        repeat (3) @(negedge clk);
        chk("R11 strobe in reset", 32'(word_strobe), 0);
        chk("R11 word in reset", 32'(word_out), 0);
        chk("R11 flush in reset", 32'(flush_pulse), 0);
        rst_n = 1;
        // Idle slot: null word.
        wait_strobe();
        chk("R4 idle null", 32'(word_out), 32'(NULLW));
        // All destinations full with q4 armed.
        dest_full = 4'hf;
        sw_pulse(4);
        wait_strobe(); wait_strobe();
        chk("R5 all full null", 32'(word_out), 32'(NULLW));
        dest_full = 0;
        wait_strobe();
        chk("R6 sw armed q4 word0", 32'(word_out), 32'(wexp(4, 0)));
        wait_strobe();
        chk("R6 q4 word1", 32'(word_out), 32'(wexp(4, 1)));
        wait_strobe();
        chk("R8 disarmed after eoq", 32'(word_out), 32'(NULLW));
        // Priority on a shared destination: q1 rising edge vs q3 software.
        qdest[3] = 1;
        trig_mode[1*3 +: 3] = 3'd1;
        @(negedge clk) begin hw_trig[1] = 1; sw_trig[3] = 1; end
        @(negedge clk) sw_trig[3] = 0;
        wait_strobe(); chk("R2 q1 first", 32'(word_out), 32'(wexp(1, 0)));
        wait_strobe(); chk("R2 q1 second", 32'(word_out), 32'(wexp(1, 1)));
        wait_strobe(); chk("R2 q3 after q1", 32'(word_out), 32'(wexp(3, 0)));
        wait_strobe(); chk("R2 q3 last", 32'(word_out), 32'(wexp(3, 1)));
        wait_strobe(); chk("R8 both done", 32'(word_out), 32'(NULLW));
        // Falling edge on q2.
        trig_mode[2*3 +: 3] = 3'd2;
        @(negedge clk) hw_trig[2] = 1;
        @(negedge clk) hw_trig[2] = 0;
        wait_strobe(); chk("R7 falling q2", 32'(word_out), 32'(wexp(2, 0)));
        wait_strobe(); wait_strobe();
        chk("R7 falling no rearm", 32'(word_out), 32'(NULLW));
        // Low level on q5.
        trig_mode[5*3 +: 3] = 3'd4;
        wait_strobe(); chk("R7 low level q5", 32'(word_out), 32'(wexp(5, 0)));
        trig_mode = 0;
        wait_strobe(); wait_strobe();
        // Queue-0 flush.
        @(negedge clk) sw_trig[0] = 1;
        @(negedge clk) begin sw_trig[0] = 0; chk("R9 flush after q0 trigger", 32'(flush_pulse), 1); end
        repeat (3) wait_strobe();
        // Coherency: q3 open sequence interrupted by q1.
        more_en[3] = 1; qlen[3] = 4;
        sw_pulse(3);
        wait_strobe(); chk("R10 q3 seq word", 32'(word_out[WW-1]), 0);
        sw_pulse(1);
        wait_strobe(); chk("R10 irq on break", 32'(coher_irq), 1);
        repeat (4) wait_strobe();
        // Randomized phase.
        for (int r = 0; r < 4000; r++) begin
            @(negedge clk);
            if (r % 200 == 0)
                for (int i = 0; i < NQ; i++) begin
                    trig_mode[i*3 +: 3] = 3'($urandom_range(0, 5));
                    qlen[i] = $urandom_range(1, 4);
                    more_en[i] = $urandom_range(0, 1);
                    qdest[i] = $urandom_range(0, NDEST - 1);
                end
            for (int i = 0; i < NQ; i++) begin
                sw_trig[i] = ($urandom_range(0, 30) == 0);
                if ($urandom_range(0, 7) == 0) hw_trig[i] = ~hw_trig[i];
                cmd_valid[i] = ($urandom_range(0, 5) != 0);
            end
            dest_full = 4'($urandom_range(0, 15) & $urandom_range(0, 15));
        end
        @(negedge clk) sw_trig = 0;
        repeat (20) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule